// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Selector

This block sits in the decode stage of a five-stage integer pipeline. It lets a conditional branch compare its two operands, and an indirect jump work out its target, before the instructions ahead of them have written the register file. It looks at the two source register indices of the instruction in decode and at the destination index, write enable and load flag of the instructions in the execute, memory and write-back stages. From these it works out, for each source operand, which newer value must be used in place of the stale register-file copy.

The result is given as a 4-bit select code for each operand. The block also contains the operand multiplexers that act on those codes. They feed the branch comparator (two operands) and the indirect-jump adder, whose second operand is always the I-type immediate.

The first source operand has one shared code space. Codes 1 to 5 forward to the comparator when the decoded instruction is a branch. Codes 6 to 10 forward the same five sources to the jump adder when it is not a branch. Code 0 means no forwarding. The logic is purely combinational. Stalling when a load result is not yet available is handled elsewhere.

Top module: `dfw_decode_forward`

## Requirements
- R1: A stage matches an operand only when its write enable is 1, its destination index equals the operand index, and the operand index is not 0.
- R2: When several stages match, the nearest wins: execute over memory over write-back.
- R3: An execute-stage match whose instruction is a load yields code 0 for that operand, even if an older stage also matches.
- R4: With `is_branch`=1, the source gives `rs1_sel` as follows. An execute match (not a load) gives 1 (live ALU result). A memory match gives 2, or 4 if it is a load (data-memory output). A write-back match gives 3, or 5 if it is a load (both use write-back data).
- R5: With `is_branch`=0, a nonzero first-operand source gives the R4 value plus 5, so codes 6 to 10.
- R6: `rs2_sel` follows the R4 table using the second index when `is_branch`=1, and is 0 when `is_branch`=0.
- R7: The consumer that the first-operand code addresses gets the selected source. The other consumer (`cmp_a` or `jalr_base`) gets `rf_rs1`.
- R8: `cmp_b` gets the source that `rs2_sel` selects, or `rf_rs2` for code 0.
- R9: `jalr_sum` equals `jalr_base + imm_i` modulo 2^DATA_W.
- R10: With no match on an operand, its code is 0 and every consumer of it gets the register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_idx | input | IDX_W | First source index of the decode instruction |
| rs2_idx | input | IDX_W | Second source index of the decode instruction |
| is_branch | input | 1 | Decode instruction is a conditional branch |
| ex_rd | input | IDX_W | Execute-stage destination index |
| ex_we | input | 1 | Execute-stage register write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | IDX_W | Memory-stage destination index |
| mem_we | input | 1 | Memory-stage register write enable |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | IDX_W | Write-back destination index |
| wb_we | input | 1 | Write-back register write enable |
| wb_load | input | 1 | Write-back instruction is a load |
| rf_rs1 | input | DATA_W | Register-file value of the first operand |
| rf_rs2 | input | DATA_W | Register-file value of the second operand |
| alu_live | input | DATA_W | Current ALU result in execute |
| exm_alu | input | DATA_W | ALU result held in the memory stage |
| wb_data | input | DATA_W | Data being written back to the register file |
| dmem_data | input | DATA_W | Data-memory read output |
| imm_i | input | DATA_W | Sign-extended I-type immediate |
| rs1_sel | output | SEL_W | First-operand select code |
| rs2_sel | output | SEL_W | Second-operand select code |
| cmp_a | output | DATA_W | Comparator operand A |
| cmp_b | output | DATA_W | Comparator operand B |
| jalr_base | output | DATA_W | Jump adder base operand |
| jalr_sum | output | DATA_W | Jump adder result |

## Verification
Three cases can coincide in one decode cycle:
- A write-back match and a memory match for the same operand.
- An execute-stage load that hides an older producer.
- Both operands resolving to different stages.

The bench sweeps every combination of three small index values across both operands and all three stages, with each write enable and load flag on and off, for both settings of the branch flag. Each vector is judged against a priority model written in the bench from the code table, so overlapping hits are checked against the nearest-stage rule. The load-hiding rule is checked in the same sweep.

// File: rtl/dfw_pkg.sv
// Shared types for the decode forwarding selector.
// Assumes at most five forwarding sources per consumer.
package dfw_pkg;

    // Source chosen for one operand; values equal the branch-space codes.
    typedef enum logic [2:0] {
        SRC_RF   = 3'd0,
        SRC_ALU  = 3'd1,
        SRC_EXM  = 3'd2,
        SRC_WB   = 3'd3,
        SRC_DMEM = 3'd4,
        SRC_WBLD = 3'd5
    } fwd_src_e;

    localparam int NUM_SRC   = 5;
    localparam int JALR_BASE = NUM_SRC;
    localparam int NUM_STG   = 3;
    localparam int STG_EX    = 0;
    localparam int STG_MEM   = 1;
    localparam int STG_WB    = 2;

endpackage

// File: rtl/dfw_stage_hit.sv
// Compares one source index against one pipeline stage destination.
// Assumes index 0 is the hard-wired zero register and never forwards.
module dfw_stage_hit #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             wr_en,
    output logic             hit
);
    // Match only on a live write to the same nonzero register.
    always_comb begin
        hit = wr_en && (src_idx == dst_idx) && (src_idx != '0);
    end
endmodule

// File: rtl/dfw_prio.sv
// Picks the forwarding source from per-stage hits, nearest stage first.
// Assumes hit/load bit 0 is execute, 1 is memory, 2 is write-back.
module dfw_prio
    import dfw_pkg::*;
(
    input  logic [NUM_STG-1:0] hit,
    input  logic [NUM_STG-1:0] load,
    output fwd_src_e           src
);
    // Priority chain; an execute load blocks forwarding entirely.
    always_comb begin
        if (hit[STG_EX]) begin
            src = load[STG_EX] ? SRC_RF : SRC_ALU;
        end else if (hit[STG_MEM]) begin
            src = load[STG_MEM] ? SRC_DMEM : SRC_EXM;
        end else if (hit[STG_WB]) begin
            src = load[STG_WB] ? SRC_WBLD : SRC_WB;
        end else begin
            src = SRC_RF;
        end
    end
endmodule

// File: rtl/dfw_operand_mux.sv
// Selects one consumer operand from a select code.
// Codes BASE+1..BASE+NUM_SRC address this consumer; anything else uses the register file.
module dfw_operand_mux
    import dfw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4,
    parameter int BASE   = 0
) (
    input  logic [SEL_W-1:0]  code,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] alu_live,
    input  logic [DATA_W-1:0] exm_alu,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [DATA_W-1:0] dmem_data,
    output logic [DATA_W-1:0] dout
);
    localparam logic [SEL_W-1:0] C_ALU  = SEL_W'(BASE + 1);
    localparam logic [SEL_W-1:0] C_EXM  = SEL_W'(BASE + 2);
    localparam logic [SEL_W-1:0] C_WB   = SEL_W'(BASE + 3);
    localparam logic [SEL_W-1:0] C_DMEM = SEL_W'(BASE + 4);
    localparam logic [SEL_W-1:0] C_WBLD = SEL_W'(BASE + 5);

    // Decode the code into a data source; unknown codes fall back.
    always_comb begin
        unique case (code)
            C_ALU:         dout = alu_live;
            C_EXM:         dout = exm_alu;
            C_WB, C_WBLD:  dout = wb_data;
            C_DMEM:        dout = dmem_data;
            default:       dout = rf_val;
        endcase
    end
endmodule

// File: rtl/dfw_decode_forward.sv
// Decode-stage forwarding selector for branch compare and indirect-jump target.
// Assumes stage inputs are from the pipeline registers in the same cycle;
// load-use stalls are handled by separate logic.
module dfw_decode_forward
    import dfw_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4
) (
    input  logic [IDX_W-1:0]  rs1_idx,
    input  logic [IDX_W-1:0]  rs2_idx,
    input  logic              is_branch,
    input  logic [IDX_W-1:0]  ex_rd,
    input  logic              ex_we,
    input  logic              ex_load,
    input  logic [IDX_W-1:0]  mem_rd,
    input  logic              mem_we,
    input  logic              mem_load,
    input  logic [IDX_W-1:0]  wb_rd,
    input  logic              wb_we,
    input  logic              wb_load,
    input  logic [DATA_W-1:0] rf_rs1,
    input  logic [DATA_W-1:0] rf_rs2,
    input  logic [DATA_W-1:0] alu_live,
    input  logic [DATA_W-1:0] exm_alu,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [DATA_W-1:0] dmem_data,
    input  logic [DATA_W-1:0] imm_i,
    output logic [SEL_W-1:0]  rs1_sel,
    output logic [SEL_W-1:0]  rs2_sel,
    output logic [DATA_W-1:0] cmp_a,
    output logic [DATA_W-1:0] cmp_b,
    output logic [DATA_W-1:0] jalr_base,
    output logic [DATA_W-1:0] jalr_sum
);
    localparam int NUM_OP = 2;

    logic [IDX_W-1:0]   stg_rd [NUM_STG];
    logic [NUM_STG-1:0] stg_we;
    logic [NUM_STG-1:0] stg_ld;
    logic [IDX_W-1:0]   op_idx [NUM_OP];
    fwd_src_e           op_src [NUM_OP];

    // Gather stage fields into indexable form.
    always_comb begin
        stg_rd[STG_EX]  = ex_rd;
        stg_rd[STG_MEM] = mem_rd;
        stg_rd[STG_WB]  = wb_rd;
        stg_we = {wb_we, mem_we, ex_we};
        stg_ld = {wb_load, mem_load, ex_load};
        op_idx[0] = rs1_idx;
        op_idx[1] = rs2_idx;
    end

    // One hit detector per operand and stage, then one priority picker per operand.
    for (genvar op = 0; op < NUM_OP; op++) begin : g_op
        logic [NUM_STG-1:0] hit;
        for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
            dfw_stage_hit #(.IDX_W(IDX_W)) u_hit (
                .src_idx (op_idx[op]),
                .dst_idx (stg_rd[s]),
                .wr_en   (stg_we[s]),
                .hit     (hit[s])
            );
        end
        dfw_prio u_prio (
            .hit  (hit),
            .load (stg_ld),
            .src  (op_src[op])
        );
    end

    // Map sources into the shared code spaces.
    always_comb begin
        if (op_src[0] == SRC_RF) begin
            rs1_sel = '0;
        end else if (is_branch) begin
            rs1_sel = SEL_W'(op_src[0]);
        end else begin
            rs1_sel = SEL_W'(op_src[0]) + SEL_W'(JALR_BASE);
        end
        rs2_sel = is_branch ? SEL_W'(op_src[1]) : '0;
    end

    dfw_operand_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .BASE(0)) u_mux_cmp_a (
        .code (rs1_sel), .rf_val (rf_rs1), .alu_live (alu_live), .exm_alu (exm_alu),
        .wb_data (wb_data), .dmem_data (dmem_data), .dout (cmp_a)
    );

    dfw_operand_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .BASE(JALR_BASE)) u_mux_jalr (
        .code (rs1_sel), .rf_val (rf_rs1), .alu_live (alu_live), .exm_alu (exm_alu),
        .wb_data (wb_data), .dmem_data (dmem_data), .dout (jalr_base)
    );

    dfw_operand_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W), .BASE(0)) u_mux_cmp_b (
        .code (rs2_sel), .rf_val (rf_rs2), .alu_live (alu_live), .exm_alu (exm_alu),
        .wb_data (wb_data), .dmem_data (dmem_data), .dout (cmp_b)
    );

    // Jump target adder; second operand is always the I-type immediate.
    always_comb begin
        jalr_sum = jalr_base + imm_i;
    end
endmodule

// File: rtl/dfw_decode_forward_chk.sv
// Property checker for the decode forwarding selector, bound to the top.
// Assumes combinational inputs settle before evaluation.
module dfw_decode_forward_chk #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4
) (
    input logic [IDX_W-1:0]  rs1_idx,
    input logic [IDX_W-1:0]  rs2_idx,
    input logic              is_branch,
    input logic [IDX_W-1:0]  ex_rd,
    input logic              ex_we,
    input logic              ex_load,
    input logic [IDX_W-1:0]  mem_rd,
    input logic              mem_we,
    input logic              mem_load,
    input logic [IDX_W-1:0]  wb_rd,
    input logic              wb_we,
    input logic              wb_load,
    input logic [DATA_W-1:0] rf_rs1,
    input logic [DATA_W-1:0] rf_rs2,
    input logic [DATA_W-1:0] alu_live,
    input logic [DATA_W-1:0] exm_alu,
    input logic [DATA_W-1:0] wb_data,
    input logic [DATA_W-1:0] dmem_data,
    input logic [DATA_W-1:0] imm_i,
    input logic [SEL_W-1:0]  rs1_sel,
    input logic [SEL_W-1:0]  rs2_sel,
    input logic [DATA_W-1:0] cmp_a,
    input logic [DATA_W-1:0] cmp_b,
    input logic [DATA_W-1:0] jalr_base,
    input logic [DATA_W-1:0] jalr_sum
);
    // Immediate checks on the settled combinational outputs.
    always_comb begin
        AST_ZERO_REG_NO_FWD: assert (rs1_idx != '0 || rs1_sel == '0) else $error("x0 forwarded"); // R1
        AST_EX_LOAD_HOLD: assert (!(ex_we && ex_load && ex_rd == rs1_idx && rs1_idx != '0) || rs1_sel == '0) else $error("ex load forwarded"); // R3
        AST_BRANCH_SPACE: assert (!is_branch || rs1_sel <= SEL_W'(5)) else $error("branch code out of space"); // R4
        AST_JALR_SPACE: assert (is_branch || rs1_sel == '0 || (rs1_sel >= SEL_W'(6) && rs1_sel <= SEL_W'(10))) else $error("jalr code out of space"); // R5
        AST_RS2_BRANCH_ONLY: assert (is_branch || rs2_sel == '0) else $error("rs2 code without branch"); // R6
        AST_IDLE_CONSUMER_RF: assert (is_branch ? (jalr_base == rf_rs1) : (cmp_a == rf_rs1)) else $error("idle consumer not fed from register file"); // R7
        AST_NOHIT_RF: assert (rs2_sel != '0 || cmp_b == rf_rs2) else $error("cmp_b not register file on code 0"); // R10
    end
endmodule

bind dfw_decode_forward dfw_decode_forward_chk #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/sim_dfw_decode_forward.sv
// Near-exhaustive sweep of the decode forwarding selector over indices 0..2.
module sim_dfw_decode_forward;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 5;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 4;
    localparam int WATCHDOG_CYC = 200000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [IDX_W-1:0]  rs1_idx, rs2_idx, ex_rd, mem_rd, wb_rd;
    logic              is_branch, ex_we, ex_load, mem_we, mem_load, wb_we, wb_load;
    logic [DATA_W-1:0] rf_rs1, rf_rs2, alu_live, exm_alu, wb_data, dmem_data, imm_i;
    logic [SEL_W-1:0]  rs1_sel, rs2_sel;
    logic [DATA_W-1:0] cmp_a, cmp_b, jalr_base, jalr_sum;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    dfw_decode_forward #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u0 (
        .rs1_idx, .rs2_idx, .is_branch,
        .ex_rd, .ex_we, .ex_load, .mem_rd, .mem_we, .mem_load,
        .wb_rd, .wb_we, .wb_load,
        .rf_rs1, .rf_rs2, .alu_live, .exm_alu, .wb_data, .dmem_data, .imm_i,
        .rs1_sel, .rs2_sel, .cmp_a, .cmp_b, .jalr_base, .jalr_sum
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Spec model: branch-space code for an operand index.
    function automatic int exp_src(input int rs, input int er, input bit ew, input bit el,
                                   input int mr, input bit mw, input bit ml,
                                   input int wr, input bit ww, input bit wl);
        if (rs == 0) return 0;
        if (ew && er == rs) return el ? 0 : 1;
        if (mw && mr == rs) return ml ? 4 : 2;
        if (ww && wr == rs) return wl ? 5 : 3;
        return 0;
    endfunction

    function automatic logic [31:0] src_val(input int s, input logic [31:0] rf);
        case (s)
            1: return alu_live;
            2: return exm_alu;
            3, 5: return wb_data;
            4: return dmem_data;
            default: return rf;
        endcase
    endfunction

    initial begin
        rf_rs1 = 32'h1000_0001; rf_rs2 = 32'h2000_0002;
        alu_live = 32'hA000_000A; exm_alu = 32'hB000_000B;
        wb_data = 32'hC000_000C; dmem_data = 32'hD000_000D;
        imm_i = 32'h0000_0FF0;
        rs1_idx = '0; rs2_idx = '0; is_branch = 1'b0;
        ex_rd = '0; ex_we = 1'b0; ex_load = 1'b0;
        mem_rd = '0; mem_we = 1'b0; mem_load = 1'b0;
        wb_rd = '0; wb_we = 1'b0; wb_load = 1'b0;
        #(CLK_PERIOD/2 + 1);
        // Idle state: nothing writes, all register-file values.
        check(rs1_sel == 0 && rs2_sel == 0, "R10 idle codes", {24'd0, rs1_sel, rs2_sel}, 32'd0);
        check(cmp_a == rf_rs1 && jalr_base == rf_rs1, "R10 idle rs1 data", cmp_a, rf_rs1);
        for (int br = 0; br < 2; br++) begin
            for (int r1 = 0; r1 < 3; r1++) begin
                for (int r2 = 0; r2 < 3; r2++) begin
                    for (int v = 0; v < 1728; v++) begin
                        int ve, vm, vw, s1, s2, e1, ebase, ecmpa, ecmpb, nhit;
                        string scen;
                        ve = v % 12; vm = (v / 12) % 12; vw = v / 144;
                        is_branch = br[0];
                        rs1_idx = IDX_W'(r1); rs2_idx = IDX_W'(r2);
                        ex_rd = IDX_W'(ve % 3); ex_we = ((ve / 3) % 2) == 1; ex_load = (ve / 6) == 1;
                        mem_rd = IDX_W'(vm % 3); mem_we = ((vm / 3) % 2) == 1; mem_load = (vm / 6) == 1;
                        wb_rd = IDX_W'(vw % 3); wb_we = ((vw / 3) % 2) == 1; wb_load = (vw / 6) == 1;
                        imm_i = v[0] ? 32'hFFFF_FFF0 : 32'h0000_0FF0;
                        #2;
                        s1 = exp_src(r1, ve % 3, ex_we, ex_load, vm % 3, mem_we, mem_load, vw % 3, wb_we, wb_load);
                        s2 = exp_src(r2, ve % 3, ex_we, ex_load, vm % 3, mem_we, mem_load, vw % 3, wb_we, wb_load);
                        e1 = (br == 1) ? s1 : ((s1 == 0) ? 0 : s1 + 5);
                        ecmpa = (br == 1) ? src_val(s1, rf_rs1) : rf_rs1;
                        ebase = (br == 1) ? rf_rs1 : src_val(s1, rf_rs1);
                        ecmpb = (br == 1) ? src_val(s2, rf_rs2) : rf_rs2;
                        nhit = 0;
                        if (r1 != 0 && ex_we && ve % 3 == r1) nhit++;
                        if (r1 != 0 && mem_we && vm % 3 == r1) nhit++;
                        if (r1 != 0 && wb_we && vw % 3 == r1) nhit++;
                        if (nhit == 0) scen = "R10";
                        else if (ex_we && ex_load && ve % 3 == r1) scen = "R3";
                        else if (nhit > 1) scen = "R2";
                        else scen = "R1";
                        check(rs1_sel == SEL_W'(e1), {scen, (br == 1) ? " R4 rs1_sel" : " R5 rs1_sel"}, 32'(rs1_sel), 32'(e1));
                        check(rs2_sel == SEL_W'((br == 1) ? s2 : 0), "R6 rs2_sel", 32'(rs2_sel), 32'((br == 1) ? s2 : 0));
                        check(cmp_a == ecmpa, "R7 cmp_a", cmp_a, ecmpa);
                        check(jalr_base == ebase, "R7 jalr_base", jalr_base, ebase);
                        check(cmp_b == ecmpb, "R8 cmp_b", cmp_b, ecmpb);
                        check(jalr_sum == ebase + imm_i, "R9 jalr_sum", jalr_sum, ebase + imm_i);
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYC, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule